// File: doc/BRIEF.md
# Four-Channel DMA Controller Register Interface

This block is the processor-facing register file of a four-channel DMA controller. The processor reaches it through an 8-bit I/O bus with a 4-bit offset. Every channel keeps a 16-bit transfer address and a 16-bit transfer count, each in a base copy and a working copy. Both values pass through one 8-bit port per register. A single shared byte pointer decides whether an access hits the low or the high half, and each such access toggles the pointer. Further offsets hold the command byte, the software request bits, the per-channel mask bits and the per-channel mode field. Some offsets act only as commands: clearing the byte pointer, a master clear, clearing every mask, and loading every mask at once.

The transfer engine consumes the mode, mask, command and request outputs, and the working address of each channel. After each bus cycle it pulses a step for one channel. A step advances that channel's working address, upward or downward as its mode asks, and decrements its working count. A step taken at count zero is the terminal count. It sets a status flag that reading the status register clears. It then either reloads the working copies from the base copies (auto-initialise) or masks the channel.

Top module: `dma_regif`

## Requirements
- R1: After synchronous reset all four mask bits are 1, the command byte, request bits, mode fields and byte pointer are 0, and the status byte (offset 0x8 read) is 0x00.
- R2: A 16-bit channel register is written as two accesses to one offset, low byte first. Channel ch has its address at offset 2*ch and its count at offset 2*ch+1.
- R3: Any write to offset 0xC returns the byte pointer to the low-byte state, so the next access hits the low byte.
- R4: A write to an address or count byte loads both the base and the working copy. Reading a count returns the stored value, which is the wanted transfers minus one.
- R5: A write to offset 0xA sets (bit 2 = 1) or clears (bit 2 = 0) the mask bit of the channel named in bits 1:0. The other mask bits do not change.
- R6: A write to offset 0xE clears all mask bits. A write to offset 0xF copies data bits 3:0 into mask bits 3:0.
- R7: A write to offset 0xB stores data bits 7:2 as the mode of the channel named in bits 1:0, on mode_out[6*ch+5:6*ch]. Within it, data bit 5 selects address decrement and bit 4 selects auto-initialise.
- R8: A step on a channel with a nonzero count decrements the working count by one. It also moves the working address by one: down when the mode decrement bit is set, otherwise up.
- R9: A step at working count 0 is a terminal count. The count wraps to 0xFFFF and status bit ch is set. Without auto-initialise, mask bit ch is set. A status read returns {request[3:0], tc[3:0]} and clears the tc bits.
- R10: At a terminal count with auto-initialise set, the working address and count are reloaded from the base copies, and the mask bit is left unchanged.
- R11: A write to offset 0xD (master clear) sets all masks. It also clears the byte pointer, the command byte, the request bits and the status flags.
- R12: A write to offset 0x8 loads the command byte. A write to offset 0x9 sets (bit 2 = 1) or clears (bit 2 = 0) the request bit of the channel named in bits 1:0.
- R13: A read of an address or count offset toggles the byte pointer just as a write does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Register write strobe |
| io_rd | input | 1 | Register read strobe |
| io_addr | input | 4 | Register offset |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the read cycle |
| step_valid | input | 1 | Transfer engine completed one transfer |
| step_ch | input | 2 | Channel that completed the transfer |
| cmd_out | output | 8 | Command byte |
| mask_out | output | 4 | Per-channel mask bits |
| sw_req_out | output | 4 | Software request bits |
| mode_out | output | 24 | Six mode bits per channel |
| cur_addr_out | output | 64 | Working address per channel, 16 bits each |

## Verification
The channel registers are driven with distinct low and high bytes, so a swapped half or a stuck byte pointer shows up in the readback. A stray single write is followed by a pointer clear to separate R3 from plain toggling. Steps are applied in increment mode, decrement mode and auto-initialise mode, up to and past terminal count. This tells wrap-and-mask apart from reload, and the status read is repeated to prove the clear-on-read. Master clear is issued with the pointer deliberately left in the high state, so the readback that follows shows whether the pointer reset.

// File: rtl/dma_regif_pkg.sv
package dma_regif_pkg;

    localparam int NCH = 4;
    localparam int CHW = $clog2(NCH);
    localparam int BW  = 8;
    localparam int WW  = 16;
    localparam int MW  = 6;

    localparam logic [3:0] OFS_CMD     = 4'h8;
    localparam logic [3:0] OFS_REQ     = 4'h9;
    localparam logic [3:0] OFS_SMASK   = 4'hA;
    localparam logic [3:0] OFS_MODE    = 4'hB;
    localparam logic [3:0] OFS_CLRPTR  = 4'hC;
    localparam logic [3:0] OFS_MCLR    = 4'hD;
    localparam logic [3:0] OFS_CLRMASK = 4'hE;
    localparam logic [3:0] OFS_ALLMASK = 4'hF;

    typedef struct packed {
        logic [1:0] xfer_type;
        logic       decr;
        logic       autoinit;
        logic [1:0] dir;
    } mode_t;

    typedef struct packed {
        logic wr_cmd;
        logic wr_req;
        logic wr_smask;
        logic wr_mode;
        logic wr_clrptr;
        logic wr_mclr;
        logic wr_clrmask;
        logic wr_allmask;
        logic rd_status;
        logic ch_access;
    } strobe_t;

    function automatic mode_t mode_from_byte(input logic [BW-1:0] b);
        return mode_t'(b[BW-1:2]);
    endfunction

    function automatic logic [BW-1:0] pick_half(input logic [WW-1:0] w, input logic hi);
        return hi ? w[WW-1 -: BW] : w[BW-1:0];
    endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_regif_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_addr,
    input  logic          wr_cnt,
    input  logic          hi_sel,
    input  logic [BW-1:0] wdata,
    input  logic          step,
    input  logic          decr,
    input  logic          autoinit,
    output logic [WW-1:0] cur_addr,
    output logic [WW-1:0] cur_cnt,
    output logic          tc_pulse
);

    logic [WW-1:0] base_addr;
    logic [WW-1:0] base_cnt;
    logic          cnt_step;
    logic          addr_step;

    assign cnt_step  = step && !wr_cnt;
    assign addr_step = step && !wr_addr;
    assign tc_pulse  = cnt_step && (cur_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            cur_addr  <= '0;
        end else if (wr_addr) begin
            if (hi_sel) begin
                base_addr[WW-1 -: BW] <= wdata;
                cur_addr[WW-1 -: BW]  <= wdata;
            end else begin
                base_addr[BW-1:0] <= wdata;
                cur_addr[BW-1:0]  <= wdata;
            end
        end else if (addr_step) begin
            if (tc_pulse && autoinit)
                cur_addr <= base_addr;
            else if (decr)
                cur_addr <= cur_addr - 1'b1;
            else
                cur_addr <= cur_addr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_cnt <= '0;
            cur_cnt  <= '0;
        end else if (wr_cnt) begin
            if (hi_sel) begin
                base_cnt[WW-1 -: BW] <= wdata;
                cur_cnt[WW-1 -: BW]  <= wdata;
            end else begin
                base_cnt[BW-1:0] <= wdata;
                cur_cnt[BW-1:0]  <= wdata;
            end
        end else if (cnt_step) begin
            if (tc_pulse && autoinit)
                cur_cnt <= base_cnt;
            else
                cur_cnt <= cur_cnt - 1'b1;
        end
    end

    // R8: working count falls by one per non-terminal step
    assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_cnt && cur_cnt != '0) |=> (cur_cnt == $past(cur_cnt) - 1'b1));

    // R9: terminal count without reload wraps to all ones
    assert_tc_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        (tc_pulse && !autoinit) |=> (cur_cnt == '1));

    // R10: terminal count with reload restores the base count
    assert_autoinit_reload_R10: assert property (@(posedge clk) disable iff (rst)
        (tc_pulse && autoinit) |=> (cur_cnt == $past(base_cnt)));

endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
    import dma_regif_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  strobe_t        stb,
    input  logic [BW-1:0]  wdata,
    input  logic [NCH-1:0] tc_pulse,
    output logic           ptr_hi,
    output logic [BW-1:0]  cmd_q,
    output logic [NCH-1:0] req_q,
    output logic [NCH-1:0] mask_q,
    output mode_t          mode_q [NCH],
    output logic [BW-1:0]  status_byte
);

    logic [NCH-1:0] tc_q;
    logic [NCH-1:0] mask_d;
    logic [CHW-1:0] sel_ch;

    assign sel_ch      = wdata[CHW-1:0];
    assign status_byte = {req_q, tc_q};

    always_ff @(posedge clk) begin
        if (rst || stb.wr_mclr || stb.wr_clrptr)
            ptr_hi <= 1'b0;
        else if (stb.ch_access)
            ptr_hi <= !ptr_hi;
    end

    always_ff @(posedge clk) begin
        if (rst || stb.wr_mclr)
            cmd_q <= '0;
        else if (stb.wr_cmd)
            cmd_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || stb.wr_mclr)
            req_q <= '0;
        else if (stb.wr_req)
            req_q[sel_ch] <= wdata[2];
    end

    always_comb begin
        mask_d = mask_q;
        if (stb.wr_mclr)
            mask_d = '1;
        else if (stb.wr_clrmask)
            mask_d = '0;
        else if (stb.wr_allmask)
            mask_d = wdata[NCH-1:0];
        else if (stb.wr_smask)
            mask_d[sel_ch] = wdata[2];
        for (int i = 0; i < NCH; i++)
            if (tc_pulse[i] && !mode_q[i].autoinit)
                mask_d[i] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '1;
        else
            mask_q <= mask_d;
    end

    always_ff @(posedge clk) begin
        if (rst || stb.wr_mclr)
            tc_q <= '0;
        else
            tc_q <= (stb.rd_status ? '0 : tc_q) | tc_pulse;
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_mode
            always_ff @(posedge clk) begin
                if (rst)
                    mode_q[g] <= '0;
                else if (stb.wr_mode && sel_ch == CHW'(g))
                    mode_q[g] <= mode_from_byte(wdata);
            end
        end
    endgenerate

    // R3: pointer clear takes effect on the next cycle
    assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (rst)
        stb.wr_clrptr |=> !ptr_hi);

    // R13: channel register access flips the pointer
    assert_ptr_toggle_R13: assert property (@(posedge clk) disable iff (rst)
        (stb.ch_access && !stb.wr_clrptr && !stb.wr_mclr) |=> (ptr_hi != $past(ptr_hi)));

    // R11: master clear leaves every channel masked and status empty
    assert_mclr_R11: assert property (@(posedge clk) disable iff (rst)
        stb.wr_mclr |=> (mask_q == '1 && status_byte == '0 && cmd_q == '0));

    // R5: single mask write lands on the named channel
    assert_smask_R5: assert property (@(posedge clk) disable iff (rst)
        (stb.wr_smask && tc_pulse == '0) |=> (mask_q[$past(sel_ch)] == $past(wdata[2])));

    // R9: terminal count without reload masks the channel
    assert_tc_mask_R9: assert property (@(posedge clk) disable iff (rst)
        (tc_pulse[0] && !mode_q[0].autoinit) |=> mask_q[0]);

endmodule

// File: rtl/dma_regif.sv
module dma_regif
    import dma_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [3:0]        io_addr,
    input  logic [BW-1:0]     io_wdata,
    output logic [BW-1:0]     io_rdata,
    input  logic              step_valid,
    input  logic [CHW-1:0]    step_ch,
    output logic [BW-1:0]     cmd_out,
    output logic [NCH-1:0]    mask_out,
    output logic [NCH-1:0]    sw_req_out,
    output logic [NCH*MW-1:0] mode_out,
    output logic [NCH*WW-1:0] cur_addr_out
);

    strobe_t        stb;
    logic           ptr_hi;
    logic           ch_space;
    logic [CHW-1:0] acc_ch;
    logic [NCH-1:0] tc_pulse;
    mode_t          mode_q [NCH];
    logic [BW-1:0]  status_byte;
    logic [WW-1:0]  caddr [NCH];
    logic [WW-1:0]  ccnt  [NCH];

    assign ch_space = (io_addr[3] == 1'b0);
    assign acc_ch   = io_addr[CHW:1];

    always_comb begin
        stb            = '0;
        stb.ch_access  = ch_space && (io_wr || io_rd);
        stb.rd_status  = io_rd && io_addr == OFS_CMD;
        if (io_wr) begin
            case (io_addr)
                OFS_CMD:     stb.wr_cmd     = 1'b1;
                OFS_REQ:     stb.wr_req     = 1'b1;
                OFS_SMASK:   stb.wr_smask   = 1'b1;
                OFS_MODE:    stb.wr_mode    = 1'b1;
                OFS_CLRPTR:  stb.wr_clrptr  = 1'b1;
                OFS_MCLR:    stb.wr_mclr    = 1'b1;
                OFS_CLRMASK: stb.wr_clrmask = 1'b1;
                OFS_ALLMASK: stb.wr_allmask = 1'b1;
                default: ;
            endcase
        end
    end

    dma_ctrl_regs u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .stb         (stb),
        .wdata       (io_wdata),
        .tc_pulse    (tc_pulse),
        .ptr_hi      (ptr_hi),
        .cmd_q       (cmd_out),
        .req_q       (sw_req_out),
        .mask_q      (mask_out),
        .mode_q      (mode_q),
        .status_byte (status_byte)
    );

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            logic hit;
            assign hit = io_wr && ch_space && acc_ch == CHW'(g);
            dma_chan_regs u_chan (
                .clk      (clk),
                .rst      (rst),
                .wr_addr  (hit && !io_addr[0]),
                .wr_cnt   (hit && io_addr[0]),
                .hi_sel   (ptr_hi),
                .wdata    (io_wdata),
                .step     (step_valid && step_ch == CHW'(g)),
                .decr     (mode_q[g].decr),
                .autoinit (mode_q[g].autoinit),
                .cur_addr (caddr[g]),
                .cur_cnt  (ccnt[g]),
                .tc_pulse (tc_pulse[g])
            );
            assign mode_out[g*MW +: MW]     = mode_q[g];
            assign cur_addr_out[g*WW +: WW] = caddr[g];
        end
    endgenerate

    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            if (ch_space)
                io_rdata = pick_half(io_addr[0] ? ccnt[acc_ch] : caddr[acc_ch], ptr_hi);
            else if (io_addr == OFS_CMD)
                io_rdata = status_byte;
        end
    end

    // R6: clear-mask command empties every mask bit
    assert_clrmask_R6: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == OFS_CLRMASK && tc_pulse == '0) |=> (mask_out == '0));

    // R12: request write lands on the named channel
    assert_req_R12: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == OFS_REQ) |=> (sw_req_out[$past(io_wdata[CHW-1:0])] == $past(io_wdata[2])));

endmodule

// File: tb/sim_dma_regif.sv
module sim_dma_regif;
    import dma_regif_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              io_wr = 1'b0, io_rd = 1'b0;
    logic [3:0]        io_addr = '0;
    logic [7:0]        io_wdata = '0;
    logic [7:0]        io_rdata;
    logic              step_valid = 1'b0;
    logic [1:0]        step_ch = '0;
    logic [7:0]        cmd_out;
    logic [3:0]        mask_out, sw_req_out;
    logic [23:0]       mode_out;
    logic [63:0]       cur_addr_out;

    int    n_chk = 0, n_fail = 0;
    bit    done = 1'b0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2 clk = ~clk;

    dma_regif u0 (.*);

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(posedge clk); #1;
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        io_rd = 1'b1; io_addr = a;
        @(posedge clk); #1;
        io_rd = 1'b0;
    endtask

    task automatic step(input logic [1:0] c);
        step_valid = 1'b1; step_ch = c;
        @(posedge clk); #1;
        step_valid = 1'b0;
    endtask

    // monitor: pops expected read bytes, compares away from the clock edge
    always @(negedge clk) begin
        if (io_rd) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL scoreboard: actual %0h expected none", io_rdata);
            end else begin
                check(tag_q.pop_front(), 64'(io_rdata), 64'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        rst = 1'b0;
        // R1 reset state
        check("R1 mask", 64'(mask_out), 64'hF);
        check("R1 cmd", 64'(cmd_out), 64'h0);
        check("R1 mode", 64'(mode_out), 64'h0);
        check("R1 req", 64'(sw_req_out), 64'h0);
        rd(4'h8, 8'h00, "R1 status");

        // R2 / R4 / R13: 16-bit values through 8-bit ports
        wr(4'hC, 8'h00);
        wr(4'h2, 8'h34); wr(4'h2, 8'h12);
        wr(4'h3, 8'h02); wr(4'h3, 8'h00);
        check("R4 working addr ch1", 64'(cur_addr_out[31:16]), 64'h1234);
        rd(4'h2, 8'h34, "R2 addr lo"); rd(4'h2, 8'h12, "R13 addr hi after read toggle");
        rd(4'h3, 8'h02, "R4 count lo"); rd(4'h3, 8'h00, "R4 count hi");

        // R3: stray write then pointer clear
        wr(4'h4, 8'hAA); wr(4'hC, 8'h00);
        wr(4'h4, 8'hBB); wr(4'h4, 8'hCC);
        rd(4'h4, 8'hBB, "R3 lo after clear"); rd(4'h4, 8'hCC, "R3 hi after clear");
        wr(4'h5, 8'h05); wr(4'h5, 8'h00);

        // R5 single mask
        wr(4'hA, 8'h01); check("R5 unmask ch1", 64'(mask_out), 64'hD);
        wr(4'hA, 8'h05); check("R5 mask ch1", 64'(mask_out), 64'hF);
        // R6 clear all / load all
        wr(4'hE, 8'h00); check("R6 clear all", 64'(mask_out), 64'h0);
        wr(4'hF, 8'h0A); check("R6 load all", 64'(mask_out), 64'hA);
        wr(4'hF, 8'h0F);

        // R7 modes
        wr(4'hB, 8'h45); check("R7 ch1 mode", 64'(mode_out[11:6]), 64'h11);
        wr(4'hB, 8'h5B); check("R7 ch3 mode", 64'(mode_out[23:18]), 64'h16);
        wr(4'hB, 8'h66); check("R7 ch2 mode", 64'(mode_out[17:12]), 64'h19);

        // R8 step increment and decrement
        step(2'd1);
        check("R8 ch1 addr inc", 64'(cur_addr_out[31:16]), 64'h1235);
        rd(4'h3, 8'h01, "R8 ch1 count lo"); rd(4'h3, 8'h00, "R8 ch1 count hi");
        step(2'd2);
        check("R8 ch2 addr dec", 64'(cur_addr_out[47:32]), 64'hCCBA);

        // R9 terminal count without auto-initialise
        wr(4'hA, 8'h01); check("R9 pre mask", 64'(mask_out), 64'hD);
        step(2'd1); step(2'd1);
        check("R9 tc masks ch1", 64'(mask_out), 64'hF);
        rd(4'h3, 8'hFF, "R9 wrap lo"); rd(4'h3, 8'hFF, "R9 wrap hi");
        rd(4'h8, 8'h02, "R9 status tc"); rd(4'h8, 8'h00, "R9 status cleared");

        // R10 terminal count with auto-initialise
        wr(4'h6, 8'h00); wr(4'h6, 8'h80);
        wr(4'h7, 8'h01); wr(4'h7, 8'h00);
        wr(4'hA, 8'h03); check("R10 pre mask", 64'(mask_out), 64'h7);
        step(2'd3); step(2'd3);
        check("R10 addr reload", 64'(cur_addr_out[63:48]), 64'h8000);
        check("R10 mask kept", 64'(mask_out), 64'h7);
        rd(4'h7, 8'h01, "R10 count lo"); rd(4'h7, 8'h00, "R10 count hi");
        rd(4'h8, 8'h08, "R10 status tc");

        // R12 command and request
        wr(4'h8, 8'h5A); check("R12 cmd", 64'(cmd_out), 64'h5A);
        wr(4'h9, 8'h06); check("R12 req set", 64'(sw_req_out), 64'h4);
        rd(4'h8, 8'h40, "R12 status req");
        wr(4'h9, 8'h02); check("R12 req clr", 64'(sw_req_out), 64'h0);
        wr(4'h9, 8'h05); check("R12 req ch1", 64'(sw_req_out), 64'h2);

        // R11 master clear with pointer left high
        wr(4'h0, 8'h77);
        wr(4'hD, 8'h00);
        check("R11 mask", 64'(mask_out), 64'hF);
        check("R11 cmd", 64'(cmd_out), 64'h0);
        check("R11 req", 64'(sw_req_out), 64'h0);
        rd(4'h8, 8'h00, "R11 status");
        wr(4'h0, 8'h11); wr(4'h0, 8'h22);
        rd(4'h0, 8'h11, "R11 ptr lo"); rd(4'h0, 8'h22, "R11 ptr hi");

        repeat (3) @(posedge clk);
        check("scoreboard drained", 64'(exp_q.size()), 64'h0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule